// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local 32-bit bus and a link interface. It turns local addresses that fall inside a fixed outbound aperture into 64-bit link addresses. The aperture starts at local address 0x60000000. It is cut into a programmable number of equal windows. Each window has its own enable, a low offset word and a high offset word. One shared size code sets the width of every window to 1, 2, 4 or 8 MB.

A single write port programs the per-window words and a control word. The control word holds a global enable and the size code. When the global enable is clear, translation is skipped and addresses pass through zero-extended. Each lookup request is answered one cycle later with the translated address and two flags. The hit flag marks a good translation. The error flag marks an address that could not be translated.

Top module: `ob_window_xlat`

## Requirements
- R1: After reset the global enable is 0, the size code is 0, and every window's offset words are 0 with the window disabled. The response valid output is 0.
- R2: A response valid pulse appears exactly one cycle after each request valid, and at no other time. While response valid is 0, hit and error are both 0.
- R3: While the global enable is 0, every request returns the local address zero-extended to 64 bits, with hit=0 and error=0.
- R4: With the global enable set, the window index is (address − 0x60000000) >> (20 + size code). Size codes 0, 1, 2 and 3 give windows of 1, 2, 4 and 8 MB.
- R5: A request that reaches an enabled window returns hit=1 and error=0. The address is {high word, (low word with its bits below the window size cleared) | (address bits below the window size)}.
- R6: Bit 0 of a window's low word is that window's enable. A request that reaches a disabled window while translation is on returns error=1 and hit=0.
- R7: While translation is on, an address below 0x60000000, or one whose index is not below the window count, returns error=1 and hit=0.
- R8: Whenever error is 1, the address output is the local address zero-extended to 64 bits.
- R9: The write address is {window index, kind[1:0]}. Kind 0 writes the low word and kind 1 writes the high word. Kind 2 writes the control word: bit 0 is the global enable and bits 2:1 are the size code. Kind 3 writes nothing.
- R10: A request in the same cycle as a register write is translated with the register values from before that write. The write applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | IDX_W+2 | Write address: {window index, kind} |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_hit | output | 1 | Translation done through an enabled window |
| rsp_error | output | 1 | Address outside the aperture or in a disabled window |

## Verification
The bench builds the block with four windows, so the full aperture at every size code is only four windows wide. It can then sweep each of the four size codes over every window. In each window it probes the first, a middle and the last address. It also probes just below the base and the first address past the last window. With one window disabled, a nonzero high word on another, and low words whose bits straddle the window boundary, each sweep covers the enable bit, offset masking and 64-bit composition at every window size.

// File: rtl/ob_xlat_pkg.sv
// Package: types shared by the outbound window translator.
// Assumes: nothing beyond IEEE 1800-2017.
package ob_xlat_pkg;

    // Kind field in the low two bits of the register write address.
    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

    // One lookup result before it is registered.
    typedef struct packed {
        logic        hit;
        logic        err;
        logic [63:0] addr;
    } xlat_res_t;

endpackage

// File: rtl/ob_xlat_regs.sv
// Module: holds the window table and the control word, written one
// word per cycle from the register write port.
// Assumes: NUM_WIN >= 2; a write address with an index at or above
// NUM_WIN matches no window and has no effect on the table.
module ob_xlat_regs
    import ob_xlat_pkg::*;
#(
    parameter int NUM_WIN = 32,
    parameter int SIZE_W  = 2,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W+1:0]          cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output logic                      glb_en,
    output logic [SIZE_W-1:0]         size_code,
    output logic [NUM_WIN-1:0][31:0]  lo_tbl,
    output logic [NUM_WIN-1:0][31:0]  hi_tbl
);

    reg_kind_e        kind;
    logic [IDX_W-1:0] widx;

    // Split the write address into kind and window index.
    always_comb begin
        kind = reg_kind_e'(cfg_addr[1:0]);
        widx = cfg_addr[IDX_W+1:2];
    end

    // Control word: global enable and size code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en    <= 1'b0;
            size_code <= '0;
        end else if (cfg_we && kind == REG_CTL) begin
            glb_en    <= cfg_wdata[0];
            size_code <= cfg_wdata[SIZE_W:1];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // Per-window low and high offset words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_tbl[w] <= '0;
                hi_tbl[w] <= '0;
            end else if (cfg_we && widx == IDX_W'(w)) begin
                if (kind == REG_LO) lo_tbl[w] <= cfg_wdata;
                if (kind == REG_HI) hi_tbl[w] <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/ob_xlat_decode.sv
// Module: combinational lookup. It finds the window for a local
// address, checks the aperture and the window enable, and builds the
// 64-bit link address.
// Assumes: APERTURE_BASE is aligned to the largest window size, so the
// address bits below the window size equal the offset bits.
module ob_xlat_decode
    import ob_xlat_pkg::*;
#(
    parameter int          NUM_WIN       = 32,
    parameter int          SIZE_W        = 2,
    parameter int          BASE_SHIFT    = 20,
    parameter logic [31:0] APERTURE_BASE = 32'h6000_0000,
    localparam int         IDX_W         = $clog2(NUM_WIN)
) (
    input  logic [31:0]              addr,
    input  logic                     glb_en,
    input  logic [SIZE_W-1:0]        size_code,
    input  logic [NUM_WIN-1:0][31:0] lo_tbl,
    input  logic [NUM_WIN-1:0][31:0] hi_tbl,
    output xlat_res_t                res
);

    logic [31:0]      shamt;
    logic [31:0]      win_mask;
    logic [31:0]      offs;
    logic [31:0]      idx_full;
    logic [IDX_W-1:0] idx;
    logic             in_ap;
    logic [31:0]      lo_sel;
    logic [31:0]      hi_sel;

    // Window geometry and index from the size code.
    always_comb begin
        shamt    = 32'(BASE_SHIFT) + 32'(size_code);
        win_mask = (32'h1 << shamt) - 32'h1;
        offs     = addr - APERTURE_BASE;
        idx_full = offs >> shamt;
        in_ap    = (addr >= APERTURE_BASE) && (idx_full < 32'(NUM_WIN));
        idx      = idx_full[IDX_W-1:0];
        lo_sel   = lo_tbl[idx];
        hi_sel   = hi_tbl[idx];
    end

    // Pick pass-through, error or translated result.
    always_comb begin
        res.hit  = 1'b0;
        res.err  = 1'b0;
        res.addr = {32'h0, addr};
        if (glb_en) begin
            if (in_ap && lo_sel[0]) begin
                res.hit  = 1'b1;
                res.addr = {hi_sel, (lo_sel & ~win_mask) | (addr & win_mask)};
            end else begin
                res.err  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ob_window_xlat.sv
// Module: top of the outbound address window translator. It joins the
// register table and the lookup, and registers the result one cycle
// after each request.
// Assumes: the request and register write ports share one clock. A
// request sees the table as it stood before any write in the same cycle.
module ob_window_xlat
    import ob_xlat_pkg::*;
#(
    parameter int          NUM_WIN       = 32,
    parameter int          SIZE_W        = 2,
    parameter int          BASE_SHIFT    = 20,
    parameter logic [31:0] APERTURE_BASE = 32'h6000_0000,
    localparam int         IDX_W         = $clog2(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W+1:0] cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             req_valid,
    input  logic [31:0]      req_addr,
    output logic             rsp_valid,
    output logic [63:0]      rsp_addr,
    output logic             rsp_hit,
    output logic             rsp_error
);

    logic                     glb_en;
    logic [SIZE_W-1:0]        size_code;
    logic [NUM_WIN-1:0][31:0] lo_tbl;
    logic [NUM_WIN-1:0][31:0] hi_tbl;
    xlat_res_t                res;

    ob_xlat_regs #(
        .NUM_WIN (NUM_WIN),
        .SIZE_W  (SIZE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .glb_en    (glb_en),
        .size_code (size_code),
        .lo_tbl    (lo_tbl),
        .hi_tbl    (hi_tbl)
    );

    ob_xlat_decode #(
        .NUM_WIN       (NUM_WIN),
        .SIZE_W        (SIZE_W),
        .BASE_SHIFT    (BASE_SHIFT),
        .APERTURE_BASE (APERTURE_BASE)
    ) u_decode (
        .addr      (req_addr),
        .glb_en    (glb_en),
        .size_code (size_code),
        .lo_tbl    (lo_tbl),
        .hi_tbl    (hi_tbl),
        .res       (res)
    );

    // Result register: loads on a request, flags clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_hit   <= 1'b0;
            rsp_error <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid & res.hit;
            rsp_error <= req_valid & res.err;
            if (req_valid) rsp_addr <= res.addr;
        end
    end

endmodule

// File: rtl/ob_window_xlat_chk.sv
// Module: assertion checker for ob_window_xlat, attached by bind.
// Assumes: it sees the top's ports plus the registered global enable.
module ob_window_xlat_chk #(
    parameter int          BASE_SHIFT    = 20,
    parameter logic [31:0] APERTURE_BASE = 32'h6000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [63:0] rsp_addr,
    input logic        rsp_hit,
    input logic        rsp_error,
    input logic        glb_en
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_flags_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_error));

    assert_hit_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_error));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !glb_en) |=>
            (rsp_addr == {32'h0, $past(req_addr)} && !rsp_hit && !rsp_error));

    assert_below_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && glb_en && req_addr < APERTURE_BASE) |=> (rsp_error && !rsp_hit));

    assert_err_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid) |=> (!rsp_error || rsp_addr == {32'h0, $past(req_addr)}));

    assert_low_bits_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid) |=>
            (!rsp_hit || rsp_addr[BASE_SHIFT-1:0] == $past(req_addr[BASE_SHIFT-1:0])));

endmodule

bind ob_window_xlat ob_window_xlat_chk #(
    .BASE_SHIFT    (BASE_SHIFT),
    .APERTURE_BASE (APERTURE_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_hit   (rsp_hit),
    .rsp_error (rsp_error),
    .glb_en    (glb_en)
);

// File: tb/ob_window_xlat_bench.sv
// Bench: sweeps every size code over every window of a four-window
// build and compares each response with an arithmetic model.
module ob_window_xlat_bench;

    localparam int          NW    = 4;
    localparam int          IW    = $clog2(NW);
    localparam logic [31:0] BASE  = 32'h6000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW+1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_addr;
    logic          rsp_hit;
    logic          rsp_error;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bench copy of the programmed registers.
    logic [31:0] m_lo [NW];
    logic [31:0] m_hi [NW];
    logic        m_en;
    logic [1:0]  m_sz;

    always #4 clk = ~clk;

    ob_window_xlat #(.NUM_WIN(NW)) u_ob_window_xlat (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_hit   (rsp_hit),
        .rsp_error (rsp_error)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Expected {hit, err, addr} from the requirements.
    function automatic logic [65:0] model(input logic [31:0] a);
        logic [31:0] m;
        logic [31:0] idx;
        m = (32'h1 << (20 + m_sz)) - 32'h1;
        if (!m_en) return {2'b00, 32'h0, a};
        if (a < BASE) return {2'b01, 32'h0, a};
        idx = (a - BASE) >> (20 + m_sz);
        if (idx >= NW) return {2'b01, 32'h0, a};
        if (!m_lo[idx][0]) return {2'b01, 32'h0, a};
        return {2'b10, m_hi[idx], (m_lo[idx] & ~m) | (a & m)};
    endfunction

    task automatic cfg_write(input int w, input logic [1:0] kind, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {IW'(w), kind};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
        if (kind == 2'd0) m_lo[w] = d;
        if (kind == 2'd1) m_hi[w] = d;
        if (kind == 2'd2) begin m_en = d[0]; m_sz = d[2:1]; end
    endtask

    task automatic do_req(input logic [31:0] a, input string tag);
        logic [65:0] e;
        e = model(a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " hit"},   64'(rsp_hit),   64'(e[65]));
        check({tag, " error"}, 64'(rsp_error), 64'(e[64]));
        check({tag, " addr"},  rsp_addr,       e[63:0]);
        @(negedge clk);
        check({tag, " R2 idle"}, {62'h0, rsp_valid, rsp_hit | rsp_error}, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_en = 1'b0;
        m_sz = 2'd0;
        for (int w = 0; w < NW; w++) begin m_lo[w] = '0; m_hi[w] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 64'(rsp_valid), 64'd0);

        // R1 and R3: global enable is off after reset, so requests pass through.
        do_req(32'h6000_0000, "R1 R3 bypass base");
        do_req(32'h1234_5678, "R3 bypass low");
        do_req(32'hFFFF_FFFF, "R3 bypass top");
        do_req(32'h6FFF_FFFF, "R3 bypass aperture");

        // R1: windows are disabled after reset.
        cfg_write(0, 2'd2, 32'h1);
        do_req(32'h6000_0000, "R1 R6 win0 disabled at reset");

        // Program the table; window 2 stays disabled (R6).
        for (int w = 0; w < NW; w++) begin
            cfg_write(w, 2'd0, 32'h8000_0000 + (32'(w) << 24) + 32'h00AB_C000 + ((w != 2) ? 32'h1 : 32'h0));
            cfg_write(w, 2'd1, (w == 1) ? 32'h0000_00C1 : 32'h0);
        end
        // R9: kind 3 changes nothing.
        cfg_write(0, 2'd3, 32'h0);

        // R4 R5 R6 R7 R8: sweep all size codes over all windows.
        for (int s = 0; s < 4; s++) begin
            cfg_write(0, 2'd2, {29'h0, 2'(s), 1'b1});
            for (int w = 0; w < NW; w++) begin
                logic [31:0] wb;
                logic [31:0] ws;
                ws = 32'h1 << (20 + s);
                wb = BASE + 32'(w) * ws;
                do_req(wb,                     $sformatf("R4 R5 R6 s%0d w%0d first", s, w));
                do_req(wb + (ws >> 1) + 32'h3, $sformatf("R4 R5 s%0d w%0d mid", s, w));
                do_req(wb + ws - 32'h1,        $sformatf("R4 R5 R8 s%0d w%0d last", s, w));
            end
            do_req(BASE - 32'h1,                    $sformatf("R7 R8 s%0d below base", s));
            do_req(BASE + 32'(NW) * (32'h1 << (20 + s)), $sformatf("R7 R8 s%0d past end", s));
        end

        // R10: write that disables window 0 lands with a request to it.
        cfg_write(0, 2'd2, 32'h1);
        begin
            logic [65:0] e;
            e = model(32'h6000_0040);
            @(negedge clk);
            cfg_we    = 1'b1;
            cfg_addr  = {IW'(0), 2'd0};
            cfg_wdata = 32'hA000_0000;
            req_valid = 1'b1;
            req_addr  = 32'h6000_0040;
            @(negedge clk);
            cfg_we    = 1'b0;
            req_valid = 1'b0;
            m_lo[0]   = 32'hA000_0000;
            check("R10 same-cycle hit", 64'(rsp_hit), 64'(e[65]));
            check("R10 same-cycle addr", rsp_addr, e[63:0]);
        end
        do_req(32'h6000_0040, "R10 R6 after write");

        // R3: turning the global enable off again restores pass-through.
        cfg_write(0, 2'd2, 32'h6);
        do_req(32'h6010_0000, "R3 bypass after disable");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule